// File: doc/BRIEF.md
# Windowed Key-Serviced Watchdog

This block is a watchdog timer that runs from a slow reference clock. Two power-of-two divider stages slow that clock into count ticks for an 8-bit up-counter. Software keeps the counter away from overflow by writing a two-value service sequence to a key register. An arm value must come first and a fire value must follow it. An optional minimum-count window turns a service that arrives too early into a fault.

When the counter overflows, or when a service arrives before the window opens, the block drives a fixed-width active-low pulse. A mode bit steers that pulse to either a reset output or an interrupt output. Configuration and key writes go through one small write port, which has a 2-bit address and an 8-bit data word.

Top module: `keyWatchdog`

## Requirements
- R1: After reset both outputs are high and the count is 0. The first divider stage defaults to /512 and the second to /1, so the first count increment happens on the 512th clock after reset is released.
- R2: A write to address 1 sets the first-stage select P from data bits [3:0] and the second-stage select S from bits [6:4]. The counter then advances once every 2^(P+1) * 2^S clocks.
- R3: A value of P above 11 acts as /4096, and a value of S of 7 acts as /64.
- R4: Writing 0x55 and then 0xAA to address 0 clears the count to 0 in the cycle of the 0xAA write.
- R5: A key write of any value other than 0x55 or 0xAA changes nothing, and the arm state is kept across it. A 0xAA write with no 0x55 before it does not clear the count. Neither does a second 0xAA after a completed pair.
- R6: Address 3 holds a window minimum. A valid key pair that arrives while the count is below a non-zero minimum does not clear the count and starts the pulse in that same cycle. A pair that arrives at or above the minimum clears the count and starts no pulse.
- R7: A window minimum of 0 accepts a valid key pair at any count.
- R8: An overflow starts the pulse one count tick after the counter wraps from 255 to 0. At that point the count reads 1, and at the fastest divider setting this is 4 clocks after the count first reads 255.
- R9: Every pulse lasts exactly 512 clocks.
- R10: Address 2 bit 1 selects the output. With 0 the pulse drives the reset output, and with 1 it drives the interrupt output. The two outputs are never low together.
- R11: Address 2 bit 0 set to 1 holds the count and produces no timeout.
- R12: An overflow or a bad service that arrives during a pulse neither restarts nor extends that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog reference clock |
| rstN | input | 1 | Active-low system reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 key, 1 dividers, 2 control, 3 window |
| wrData | input | 8 | Write data |
| cntOut | output | 8 | Current watchdog count |
| rstOutN | output | 1 | Active-low reset pulse |
| intOutN | output | 1 | Active-low interrupt pulse |

## Verification
A table of divider pairs measures the distance between count steps. The table covers small and large settings and both out-of-range selects, so it separates a mistake in either stage from a mistake in the clamping. The service logic is tried with four kinds of sequence:
- an ordered pair;
- a pair with a stray value between the two writes;
- a repeated arm value;
- a lone or repeated fire value.

These sequences separate "clear on the fire value" from "clear only after arming". The window test places the same valid pair below and above a non-zero minimum and at a zero minimum. The overflow test measures the delay to the pulse and the pulse width, and a second bad service during a pulse shows whether the pulse is retriggered.

// File: rtl/wdogPkg.sv
package wdogPkg;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam int PSEL_W = 4;
  localparam int SSEL_W = 3;
  localparam int PS_FIELD_LSB = 4;

  localparam logic [1:0] ADDR_KEY = 2'd0;
  localparam logic [1:0] ADDR_DIV = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_WIN = 2'd3;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic clrCnt;
  } wdStrb_t;
endpackage

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdogPkg::*;
#(
  parameter int PRE_STAGES  = 12,
  parameter int PS_STAGES   = 6,
  parameter int PRE_RST_SEL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  wdStrb_t           strb,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovfEvt,
  output logic              modeInt,
  output logic [CNT_W-1:0]  winMin
);
  localparam int SH_W = PSEL_W + 1;

  logic [PSEL_W-1:0]     preSel;
  logic [SSEL_W-1:0]     psSel;
  logic                  cntOff;
  logic [SH_W-1:0]       preShift;
  logic [SSEL_W-1:0]     psShift;
  logic [PRE_STAGES-1:0] preCnt, preMask;
  logic [PS_STAGES-1:0]  psCnt, psMask;
  logic                  preTick, cntTick, ovfDly;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preSel  <= PSEL_W'(PRE_RST_SEL);
      psSel   <= '0;
      cntOff  <= 1'b0;
      modeInt <= 1'b0;
      winMin  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_DIV: begin
          preSel <= wrData[PSEL_W-1:0];
          psSel  <= wrData[PS_FIELD_LSB +: SSEL_W];
        end
        ADDR_CTL: begin
          cntOff  <= wrData[0];
          modeInt <= wrData[1];
        end
        ADDR_WIN: winMin <= wrData;
        default: ;
      endcase
    end
  end

  // clamp the selects to the implemented stages
  always_comb begin
    if (preSel >= PSEL_W'(PRE_STAGES - 1)) preShift = SH_W'(PRE_STAGES);
    else                                   preShift = SH_W'(preSel) + SH_W'(1);
    if (psSel > SSEL_W'(PS_STAGES)) psShift = SSEL_W'(PS_STAGES);
    else                            psShift = psSel;
  end

  for (genvar i = 0; i < PRE_STAGES; i++) begin : gPreMask
    assign preMask[i] = (preShift > SH_W'(i));
  end
  for (genvar j = 0; j < PS_STAGES; j++) begin : gPsMask
    assign psMask[j] = (psShift > SSEL_W'(j));
  end

  assign preTick = ((preCnt & preMask) == preMask);
  assign cntTick = preTick && ((psCnt & psMask) == psMask);
  assign ovfEvt  = cntTick && !cntOff && ovfDly && !strb.clrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      psCnt  <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (preTick) psCnt <= psCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      ovfDly <= 1'b0;
    end else if (strb.clrCnt) begin
      cnt    <= '0;
      ovfDly <= 1'b0;
    end else if (cntTick && !cntOff) begin
      cnt    <= cnt + 1'b1;
      ovfDly <= (cnt == {CNT_W{1'b1}});
    end
  end
endmodule

// File: rtl/wdogControl.sv
module wdogControl
  import wdogPkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA,
  parameter int                PULSE_LEN = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovfEvt,
  input  logic              modeInt,
  input  logic [CNT_W-1:0]  winMin,
  output wdStrb_t           strb,
  output logic              rstOutN,
  output logic              intOutN
);
  localparam int PL_W = $clog2(PULSE_LEN);

  logic            armed, keyWr, keyFire, early, badKey, pulseOn;
  logic [PL_W-1:0] pulseCnt;

  assign keyWr   = wrEn && (wrAddr == ADDR_KEY);
  assign keyFire = keyWr && (wrData == KEY_FIRE) && armed;
  assign early   = (winMin != '0) && (cnt < winMin);
  assign badKey  = keyFire && early;
  assign strb.clrCnt = keyFire && !early;

  // arm state: set by the arm value, consumed by the fire value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               armed <= 1'b0;
    else if (keyWr && wrData == KEY_ARM)     armed <= 1'b1;
    else if (keyWr && wrData == KEY_FIRE)    armed <= 1'b0;
  end

  // fixed-width pulse, not retriggerable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
    end else if (!pulseOn) begin
      if (badKey || ovfEvt) begin
        pulseOn  <= 1'b1;
        pulseCnt <= '0;
      end
    end else begin
      pulseCnt <= pulseCnt + 1'b1;
      if (pulseCnt == PL_W'(PULSE_LEN - 1)) pulseOn <= 1'b0;
    end
  end

  assign rstOutN = !(pulseOn && !modeInt);
  assign intOutN = !(pulseOn && modeInt);
endmodule

// File: rtl/keyWatchdog.sv
module keyWatchdog
  import wdogPkg::*;
#(
  parameter int PRE_STAGES  = 12,
  parameter int PS_STAGES   = 6,
  parameter int PRE_RST_SEL = 8,
  parameter int PULSE_LEN   = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntOut,
  output logic              rstOutN,
  output logic              intOutN
);
  wdStrb_t          strbBus;
  logic             ovfEvt, modeInt;
  logic [CNT_W-1:0] winMin;

  wdogDatapath #(
    .PRE_STAGES(PRE_STAGES), .PS_STAGES(PS_STAGES), .PRE_RST_SEL(PRE_RST_SEL)
  ) dpI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strbBus), .cnt(cntOut), .ovfEvt(ovfEvt), .modeInt(modeInt), .winMin(winMin)
  );

  wdogControl #(.PULSE_LEN(PULSE_LEN)) ctlI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cnt(cntOut), .ovfEvt(ovfEvt), .modeInt(modeInt), .winMin(winMin),
    .strb(strbBus), .rstOutN(rstOutN), .intOutN(intOutN)
  );
endmodule

// File: rtl/keyWatchdogChecker.sv
module keyWatchdogChecker #(
  parameter int PULSE_LEN = 512
) (
  input logic       clk,
  input logic       rstN,
  input logic       rstOutN,
  input logic       intOutN,
  input logic [7:0] cntOut,
  input logic       clrCnt
);
  logic       pulseOn;
  logic [10:0] lenCnt;

  assign pulseOn = !rstOutN || !intOutN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lenCnt <= '0;
    else if (pulseOn) lenCnt <= lenCnt + 1'b1;
    else              lenCnt <= '0;
  end

  // R4
  clear_on_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> (cntOut == 8'd0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cntOut) |-> (cntOut == 8'($past(cntOut) + 8'd1)) || (cntOut == 8'd0));

  // R10
  one_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rstOutN && !intOutN));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOn) |-> (lenCnt == 11'(PULSE_LEN)));

  // R12
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenCnt <= 11'(PULSE_LEN));
endmodule

bind keyWatchdog keyWatchdogChecker chkI (
  .clk(clk), .rstN(rstN), .rstOutN(rstOutN), .intOutN(intOutN),
  .cntOut(cntOut), .clrCnt(strbBus.clrCnt)
);

// File: tb/tb_keyWatchdog.sv
module tb_keyWatchdog;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 190000;
  localparam int NVEC = 7;
  // {P select, S select, expected clocks per count step}
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 2}, '{0, 2, 8}, '{2, 1, 16}, '{3, 3, 128},
    '{11, 0, 4096}, '{15, 0, 4096}, '{0, 7, 128}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] cntOut;
  logic       rstOutN, intOutN;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyWatchdog dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntOut(cntOut), .rstOutN(rstOutN), .intOutN(intOutN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCntGe(input int v);
    for (int k = 0; k < 20000 && cntOut < v; k++) @(negedge clk);
  endtask

  task automatic measure(output int p);
    logic [7:0] v;
    v = cntOut;
    for (int k = 0; k < 10000 && cntOut == v; k++) @(negedge clk);
    v = cntOut;
    p = 0;
    do begin
      @(posedge clk); @(negedge clk); p++;
    end while (cntOut == v && p < 10000);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG_CYCLES, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, p, w, v, lowSeen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and default divider
    chk("R1 count", cntOut, 0);
    chk("R1 rstOutN", rstOutN, 1);
    chk("R1 intOutN", intOutN, 1);
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (cntOut == 0 && n < 2000);
    chk("R1 first step", n, 512);

    // R2 / R3 divider table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd1, 8'((VEC[i][1] << 4) | VEC[i][0]));
      measure(p);
      chk((i >= 5) ? "R3 clamp period" : "R2 period", p, VEC[i][2]);
    end

    // slow setting: /2 then /64 -> 128 clocks per step
    wr(2'd1, 8'h60);
    waitCntGe(3);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R4 pair clears", cntOut, 0);
    waitCntGe(2);
    v = cntOut;
    wr(2'd0, 8'hAA);
    chk("R5 lone fire ignored", int'(cntOut >= v && v > 0), 1);
    wr(2'd0, 8'h55); wr(2'd0, 8'h3C); wr(2'd0, 8'hAA);
    chk("R5 stray keeps arm", cntOut, 0);
    waitCntGe(2);
    wr(2'd0, 8'h55); wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R5 double arm", cntOut, 0);
    waitCntGe(2);
    v = cntOut;
    wr(2'd0, 8'hAA);
    chk("R5 second fire ignored", int'(cntOut >= v && v > 0), 1);
    chk("R5 no pulse", int'(rstOutN && intOutN), 1);

    // R6 early service, R12 retrigger during pulse
    wr(2'd3, 8'd200);
    waitCntGe(1);
    v = cntOut;
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R6 early pulse", rstOutN, 0);
    chk("R6 early no clear", int'(cntOut >= v && v > 0), 1);
    w = 0;
    while (!rstOutN && w < 2000) begin
      w++;
      if (w == 50) begin wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h55; end
      if (w == 51) wrData = 8'hAA;
      if (w == 52) wrEn = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    chk("R12 width with retrigger", w, 512);
    wr(2'd3, 8'd2);
    waitCntGe(2);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R6 in-window clears", cntOut, 0);
    chk("R6 in-window no pulse", rstOutN, 1);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R7 zero window accepts", int'(rstOutN && cntOut == 0), 1);

    // R10 interrupt mode
    wr(2'd2, 8'h02);
    wr(2'd3, 8'd200);
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    chk("R10 int low", intOutN, 0);
    chk("R10 rst high", rstOutN, 1);
    repeat (520) @(negedge clk);
    chk("R10 int released", intOutN, 1);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'd0);

    // R8 / R9 overflow at fastest divider
    wr(2'd1, 8'h00);
    for (int k = 0; k < 2000 && cntOut != 8'd255; k++) @(negedge clk);
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (rstOutN && n < 100);
    chk("R8 overflow delay", n, 4);
    chk("R8 count at pulse", cntOut, 1);
    w = 0; lowSeen = 0;
    while (!rstOutN && w < 2000) begin
      w++;
      if (!intOutN) lowSeen = 1;
      @(posedge clk); @(negedge clk);
    end
    chk("R9 width", w, 512);
    chk("R10 int idle in reset mode", lowSeen, 0);

    // R11 disable
    wr(2'd2, 8'h01);
    v = cntOut;
    lowSeen = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!rstOutN || !intOutN) lowSeen = 1;
    end
    chk("R11 count held", cntOut, v);
    chk("R11 no timeout", lowSeen, 0);
    wr(2'd2, 8'h00);
    measure(p);
    chk("R11 resumes", p, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule